// File: doc/BRIEF.md
# Conditional ALU with flag generation

This block is the data-processing stage of a small integer pipeline. Each clock it takes one operation: a 4-bit opcode, a 4-bit condition code, a set-flags bit, a first operand, a second operand that has already passed through an external shifter, that shifter's carry-out, and the current flags {N, Z, C, V}. It first tests the condition code against the incoming flags. If the test passes, it performs an add, a subtract, a reverse subtract, a bitwise operation, a move or a compare. It then registers the result, a result write-enable, the next flags and an executed indicator.

The block keeps no flag state of its own. The caller passes the current flags in and keeps `flags_o` as the next value. When the condition fails, or when flags are not to be updated, `flags_o` is a copy of `flags_i`, so the caller can always load `flags_o` without extra logic. Every output is registered and appears one cycle after its inputs.

The control is a single registered stage. There is no multi-state sequencer: the only named transition is between reset (all outputs cleared) and running (outputs reloaded every cycle from the current inputs).

Top module: `cond_alu`

## Requirements
- R1: Opcode 0 gives A + B and opcode 1 gives A + B + Cin, both modulo 2^W, where Cin is the C bit of `flags_i`.
- R2: Opcodes 2 to 5 give the subtract family, all modulo 2^W:
  - opcode 2 gives A − B;
  - opcode 3 gives A − B + Cin − 1;
  - opcode 4 gives B − A;
  - opcode 5 gives B − A + Cin − 1.
- R3: Opcodes 6 to 11 give, in order, A AND B, A OR B, A XOR B, A AND NOT B, B, and NOT B.
- R4: Opcodes 12 to 15 are compares on A − B, A + B, A AND B and A XOR B respectively. When executed, they hold `wr_o` low and update the flags whatever the value of `s_i`.
- R5: For opcodes 0 to 11, when `s_i` is 0, `flags_o` equals `flags_i`.
- R6: The flags are packed {N, Z, C, V} in bits 3 down to 0. When flags are updated, N equals result bit W−1, and Z is 1 exactly when the result is zero.
- R7: For opcodes 0 to 5, 12 and 13, an update sets C to the adder carry-out. For subtraction this carry is NOT borrow, so A − B sets C when A ≥ B unsigned.
- R8: For opcodes 6 to 11, 14 and 15, an update sets C to `shc_i`.
- R9: For opcodes 0 to 5, 12 and 13, an update sets V to two's-complement signed overflow. For all other opcodes V keeps its value from `flags_i`.
- R10: Condition codes 0 to 14 pass, respectively, when:
  - Z;
  - !Z;
  - C;
  - !C;
  - N;
  - !N;
  - V;
  - !V;
  - C && !Z;
  - !C || Z;
  - N == V;
  - N != V;
  - !Z && N == V;
  - Z || N != V;
  - always.
- R11: Code 15 never passes. When the condition fails, `exe_o` and `wr_o` are 0 and `flags_o` equals `flags_i`.
- R12: Outputs are registered, one cycle after their inputs. While `rst_n` is low, `res_o`, `flags_o`, `wr_o` and `exe_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| cond_i | input | 4 | Condition code |
| s_i | input | 1 | Set-flags request for non-compare operations |
| a_i | input | W | First operand |
| b_i | input | W | Second operand, already shifted |
| shc_i | input | 1 | Shifter carry-out |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| res_o | output | W | Registered result |
| wr_o | output | 1 | Result write-enable |
| flags_o | output | 4 | Next flags {N,Z,C,V} |
| exe_o | output | 1 | Condition passed |

## Verification
The checker assumes that every input holds a known value at each clock edge. It also assumes that the `flags_i` seen at one edge is the value its hold and keep properties compare against at the next edge. No assumption is made that `flags_i` agrees with earlier outputs, because the block stores no flags. The stimulus changes every input only on the falling clock edge, so each rising edge captures one complete and stable vector. The sweeps cover:
- all sixteen opcodes against a grid of operands that includes zero, all ones and the signed extremes;
- every pairing of condition code and flag pattern.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_ADDC   = 4'd1,
        OP_SUB    = 4'd2,
        OP_SUBC   = 4'd3,
        OP_RSUB   = 4'd4,
        OP_RSUBC  = 4'd5,
        OP_AND    = 4'd6,
        OP_OR     = 4'd7,
        OP_XOR    = 4'd8,
        OP_ANDN   = 4'd9,
        OP_PASS   = 4'd10,
        OP_PASSN  = 4'd11,
        OP_CMPSUB = 4'd12,
        OP_CMPADD = 4'd13,
        OP_CMPAND = 4'd14,
        OP_CMPXOR = 4'd15
    } op_e;

    // Bit positions of the packed flag word {N,Z,C,V}
    localparam int FN = 3;
    localparam int FZ = 2;
    localparam int FC = 1;
    localparam int FV = 0;

    function automatic logic op_is_cmp(op_e o);
        return (o[3:2] == 2'b11);
    endfunction

endpackage

// File: rtl/cond_alu_cond.sv
module cond_alu_cond
    import cond_alu_pkg::*;
(
    input  logic [3:0] cond,
    input  logic [3:0] flags,
    output logic       pass
);
    logic n, z, c, v, base;

    always_comb begin
        n = flags[FN];
        z = flags[FZ];
        c = flags[FC];
        v = flags[FV];
        unique case (cond[3:1])
            3'd0: base = z;
            3'd1: base = c;
            3'd2: base = n;
            3'd3: base = v;
            3'd4: base = c & ~z;
            3'd5: base = (n == v);
            3'd6: base = ~z & (n == v);
            3'd7: base = 1'b1;
        endcase
        if (cond[3:1] == 3'd7)
            pass = ~cond[0];
        else
            pass = base ^ cond[0];
    end
endmodule

// File: rtl/cond_alu_core.sv
module cond_alu_core
    import cond_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         ovf,
    output logic         arith
);
    logic [W-1:0] x, y, lres;
    logic         k;
    logic [W:0]   sum;

    // One shared adder; subtraction inverts one operand
    always_comb begin
        x     = a;
        y     = b;
        k     = 1'b0;
        arith = 1'b1;
        unique case (op)
            OP_ADD, OP_CMPADD: ;
            OP_ADDC:           k = cin;
            OP_SUB, OP_CMPSUB: begin y = ~b; k = 1'b1; end
            OP_SUBC:           begin y = ~b; k = cin;  end
            OP_RSUB:           begin x = b; y = ~a; k = 1'b1; end
            OP_RSUBC:          begin x = b; y = ~a; k = cin;  end
            default:           arith = 1'b0;
        endcase
    end

    always_comb begin
        unique case (op)
            OP_AND, OP_CMPAND: lres = a & b;
            OP_OR:             lres = a | b;
            OP_XOR, OP_CMPXOR: lres = a ^ b;
            OP_ANDN:           lres = a & ~b;
            OP_PASS:           lres = b;
            OP_PASSN:          lres = ~b;
            default:           lres = '0;
        endcase
    end

    always_comb begin
        sum  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, k};
        res  = arith ? sum[W-1:0] : lres;
        cout = sum[W];
        ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    end
endmodule

// File: rtl/cond_alu_flags.sv
module cond_alu_flags
    import cond_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         upd,
    input  logic [W-1:0] res,
    input  logic         cout,
    input  logic         ovf,
    input  logic         arith,
    input  logic         shc,
    input  logic [3:0]   flags_in,
    output logic [3:0]   flags_next
);
    always_comb begin
        flags_next = flags_in;
        if (upd) begin
            flags_next[FN] = res[W-1];
            flags_next[FZ] = (res == '0);
            flags_next[FC] = arith ? cout : shc;
            flags_next[FV] = arith ? ovf : flags_in[FV];
        end
    end
endmodule

// File: rtl/cond_alu.sv
module cond_alu
    import cond_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   op_i,
    input  logic [3:0]   cond_i,
    input  logic         s_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         shc_i,
    input  logic [3:0]   flags_i,
    output logic [W-1:0] res_o,
    output logic         wr_o,
    output logic [3:0]   flags_o,
    output logic         exe_o
);
    op_e          op;
    logic         pass, cmp, upd, cout, ovf, arith;
    logic [W-1:0] res_d;
    logic [3:0]   flags_d;

    assign op  = op_e'(op_i);
    assign cmp = op_is_cmp(op);

    cond_alu_cond u_cond (
        .cond  (cond_i),
        .flags (flags_i),
        .pass  (pass)
    );

    cond_alu_core #(.W(W)) u_core (
        .op    (op),
        .a     (a_i),
        .b     (b_i),
        .cin   (flags_i[FC]),
        .res   (res_d),
        .cout  (cout),
        .ovf   (ovf),
        .arith (arith)
    );

    assign upd = pass & (cmp | s_i);

    cond_alu_flags #(.W(W)) u_flags (
        .upd        (upd),
        .res        (res_d),
        .cout       (cout),
        .ovf        (ovf),
        .arith      (arith),
        .shc        (shc_i),
        .flags_in   (flags_i),
        .flags_next (flags_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_o   <= '0;
            wr_o    <= 1'b0;
            flags_o <= 4'h0;
            exe_o   <= 1'b0;
        end else begin
            res_o   <= res_d;
            wr_o    <= pass & ~cmp;
            flags_o <= flags_d;
            exe_o   <= pass;
        end
    end
endmodule

// File: rtl/cond_alu_chk.sv
module cond_alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   op_i,
    input logic [3:0]   cond_i,
    input logic         s_i,
    input logic [W-1:0] res_o,
    input logic         wr_o,
    input logic [3:0]   flags_i,
    input logic [3:0]   flags_o,
    input logic         exe_o
);
    logic live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    // R11
    never_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(cond_i) == 4'hF) |-> (!exe_o && !wr_o));

    // R10
    always_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(cond_i) == 4'hE) |-> exe_o);

    // R4
    cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(op_i[3:2]) == 2'b11) |-> !wr_o);

    // R11
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !exe_o) |-> (flags_o == $past(flags_i)));

    // R5
    s_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && exe_o && !$past(s_i) && $past(op_i[3:2]) != 2'b11)
            |-> (flags_o == $past(flags_i)));

    // R6
    nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && wr_o && $past(s_i))
            |-> (flags_o[3] == res_o[W-1] && flags_o[2] == (res_o == '0)));

    // R9
    v_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && ($past(op_i) >= 4'd6) && ($past(op_i) != 4'd12) && ($past(op_i) != 4'd13))
            |-> (flags_o[0] == $past(flags_i[0])));
endmodule

bind cond_alu cond_alu_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .cond_i  (cond_i),
    .s_i     (s_i),
    .res_o   (res_o),
    .wr_o    (wr_o),
    .flags_i (flags_i),
    .flags_o (flags_o),
    .exe_o   (exe_o)
);

// File: tb/sim_cond_alu.sv
module sim_cond_alu;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    op_i = 4'd0, cond_i = 4'd14, flags_i = 4'd0;
    logic          s_i = 1'b0, shc_i = 1'b0;
    logic [BW-1:0] a_i = '0, b_i = '0;
    logic [BW-1:0] res_o;
    logic          wr_o, exe_o;
    logic [3:0]    flags_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cond_alu #(.W(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .cond_i(cond_i), .s_i(s_i),
        .a_i(a_i), .b_i(b_i), .shc_i(shc_i), .flags_i(flags_i),
        .res_o(res_o), .wr_o(wr_o), .flags_o(flags_o), .exe_o(exe_o)
    );

    function automatic int pick(int i);
        case (i)
            0: return 0;     1: return 1;     2: return 2;     3: return 127;
            4: return 128;   5: return 129;   6: return 254;   7: return 255;
            8: return 85;    9: return 170;   10: return 60;   11: return 15;
            12: return 64;   13: return 192;  14: return 16;   default: return 200;
        endcase
    endfunction

    function automatic int sgn(int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    function automatic bit cond_ok(int cd, bit n, bit z, bit c, bit v);
        case (cd)
            0: return z;          1: return !z;
            2: return c;          3: return !c;
            4: return n;          5: return !n;
            6: return v;          7: return !v;
            8: return c && !z;    9: return !c || z;
            10: return n == v;    11: return n != v;
            12: return !z && (n == v);
            13: return z || (n != v);
            14: return 1;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run(int op, int cd, bit s, int a, int b, bit shc, logic [3:0] fl);
        bit n0, z0, c0, v0, exe, cmp, ar, upd, cn, vn;
        int r, u, sr, ci;
        string rtag, ftag;
        logic [3:0] fexp;
        n0 = fl[3]; z0 = fl[2]; c0 = fl[1]; v0 = fl[0];
        ci = c0 ? 1 : 0;
        cmp = (op >= 12);
        ar = (op <= 5) || op == 12 || op == 13;
        cn = shc; vn = v0; r = 0;
        case (op)
            0, 13: begin u = a + b;      sr = sgn(a) + sgn(b); end
            1:     begin u = a + b + ci; sr = sgn(a) + sgn(b) + ci; end
            2, 12: begin u = a - b;      sr = sgn(a) - sgn(b); end
            3:     begin u = a - b + ci - 1; sr = sgn(a) - sgn(b) + ci - 1; end
            4:     begin u = b - a;      sr = sgn(b) - sgn(a); end
            5:     begin u = b - a + ci - 1; sr = sgn(b) - sgn(a) + ci - 1; end
            default: begin u = 0; sr = 0; end
        endcase
        if (ar) begin
            r  = (u + 512) % 256;
            cn = (op == 0 || op == 1 || op == 13) ? (u > 255) : (u >= 0);
            vn = (sr > 127) || (sr < -128);
        end else begin
            case (op)
                6, 14: r = a & b;
                7:     r = a | b;
                8, 15: r = a ^ b;
                9:     r = a & (255 - b);
                10:    r = b;
                default: r = 255 - b;
            endcase
        end
        exe = cond_ok(cd, n0, z0, c0, v0);
        upd = exe && (cmp || s);
        fexp = upd ? {r > 127, r == 0, cn, vn} : fl;
        rtag = (op <= 1) ? "R1" : (op <= 5) ? "R2" : (op <= 11) ? "R3" : "R4";
        ftag = (!cmp && !s) ? "R5 flags" : (!exe ? "R11 flags" : "R6 R7 R8 R9 flags");
        op_i = 4'(op); cond_i = 4'(cd); s_i = s; a_i = BW'(a); b_i = BW'(b);
        shc_i = shc; flags_i = fl;
        @(negedge clk);
        chk("R10 R11 exe", int'(exe_o), int'(exe));
        chk(cmp ? "R4 wr" : "R11 wr", int'(wr_o), int'(exe && !cmp));
        chk(ftag, int'(flags_o), int'(fexp));
        if (exe && !cmp) chk(rtag, int'(res_o), r);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R12 watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        a_i = 8'hA5; b_i = 8'h5A; s_i = 1'b1; flags_i = 4'hF;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 reset res", int'(res_o), 0);
        chk("R12 reset flags", int'(flags_o), 0);
        chk("R12 reset wr", int'(wr_o), 0);
        chk("R12 reset exe", int'(exe_o), 0);
        rst_n = 1'b1;
        // Sweep 1: every opcode over an operand grid, flags set, always condition
        for (int op = 0; op < 16; op++)
            for (int ai = 0; ai < 16; ai++)
                for (int bi = 0; bi < 16; bi++)
                    for (int ci = 0; ci < 2; ci++)
                        run(op, 14, 1'b1, pick(ai), pick(bi), bit'(ai[2] ^ bi[0]),
                            {ai[1], bi[1], ci[0], ai[0] ^ bi[0]});
        // Sweep 2: S bit clear (R5, R4 compares still update)
        for (int op = 0; op < 16; op++)
            for (int ai = 0; ai < 16; ai++)
                for (int bi = 0; bi < 16; bi += 5)
                    run(op, 14, 1'b0, pick(ai), pick(bi), bit'(bi[0]), 4'(ai + bi));
        // Sweep 3: every condition code against every flag pattern (R10 R11)
        for (int cd = 0; cd < 16; cd++)
            for (int f = 0; f < 16; f++) begin
                run(0, cd, 1'b1, 64, 64, 1'b0, 4'(f));
                run(12, cd, 1'b0, 3, 9, 1'b1, 4'(f));
                run(9, cd, 1'b1, 255, 15, 1'b1, 4'(f));
            end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule